// File: doc/BRIEF.md
# I2C Configuration Register Target

This block is a target device on a two-wire I2C-style bus. It holds a map of 24 eight-bit configuration registers at addresses 0 to 23. A controller writes the map with block writes and reads it back with block reads. An internal register pointer is set by the first byte after the address and advances by one after every data byte. SDA is driven open-drain: the block only pulls the line low through an enable output, and a pull-up elsewhere supplies the high level. SCL and SDA are sampled by a system clock, so the bus must run far slower than that clock.

The whole map is presented as one flat vector for downstream logic. Four frequency profiles are stored in the map, and their divider fields are scattered over non-adjacent registers. A decoder reassembles the integer divider, fraction, output divider and input divider of the profile picked by a 2-bit select field, and decodes a few single-bit output controls. Reset values come from a parameter.

Top module: `cfg_i2c_target`

## Requirements
- R1: While reset is asserted and after it is released, the map equals RESET_IMAGE (default: register 0 = 0x50, register 17 = 0x06, register 18 = 0x40, all others 0x00), the pointer is 0 and sdaDriveLow is 0.
- R2: The first byte after a START carries a 7-bit target address in its upper seven bits and R/W in bit 0 (0 = write, 1 = read). Address 7'b1101110 is acknowledged by pulling SDA low for the ninth clock. Any other address gets no acknowledge, and the rest of that transfer is ignored until the next START or STOP.
- R3: In a write, the byte after the address sets the pointer. Each further byte, received MSB first, is acknowledged, stored at the pointer, and the pointer then advances by one.
- R4: After a repeated START and the address with R/W = 1, the block sends the byte at the pointer MSB first, and advances the pointer for every byte sent. It sends another byte for as long as the controller acknowledges, and it releases SDA after a byte that is not acknowledged.
- R5: A transfer may stop after any complete byte. Bytes already written keep their new values and no other register changes.
- R6: A data byte written while the pointer is above 23 is acknowledged but discarded. A byte read while the pointer is above 23 is 0x00.
- R7: For the selected profile n, intDiv[4:0] = register n bits 5:1, intDiv[5] = register 20+n bit 5, and intDiv[6] = register 20+n bit 4.
- R8: For the selected profile n, fracDiv[17] = register n bit 0, fracDiv[16:9] = register 4+n, fracDiv[8:1] = register 8+n, and fracDiv[0] = register 12+n bit 7.
- R9: For the selected profile n, outDiv = register 12+n bits 6:0. inDiv[1:0] = register 20+n bits 7:6, and inDiv[2] = register 20+n bit 3.
- R10: Register 18 bits 5:4 select the profile (activeProfile). pllEnable = register 18 bit 6 (0 = bypass). Register 17 bit 3 drives refOutOff, bit 2 drives mainOutOff and bit 1 drives swingHigh.
- R11: A pulse on SCL or SDA shorter than FILT_LEN clocks after synchronisation has no effect on the transfer.
- R12: regImage bits 8k+7:8k carry register k, for k = 0 to 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaDriveLow | output | 1 | 1 pulls SDA low; 0 leaves the line released |
| regImage | output | 192 | All 24 registers, register k at bits 8k+7:8k |
| activeProfile | output | 2 | Profile selected by register 18 bits 5:4 |
| intDiv | output | 7 | Integer feedback divider of the selected profile |
| fracDiv | output | 18 | Fractional feedback divider of the selected profile |
| outDiv | output | 7 | Output divider code of the selected profile |
| inDiv | output | 3 | Input divider code of the selected profile |
| pllEnable | output | 1 | 1 = PLL path used, 0 = bypass |
| refOutOff | output | 1 | Disable for the buffered reference output |
| mainOutOff | output | 1 | Disable for the main clock output |
| swingHigh | output | 1 | Selects the larger output swing |

## Verification
A wrong bit counter or state in the byte engine shows at the ports within one byte time. The acknowledge either goes missing or falls on the wrong ninth clock, and a read byte comes back shifted. A pointer that advances wrongly, or misses the out-of-range check, shows on the next data byte, as a changed byte of regImage at the wrong position or as a non-zero byte read beyond register 23. A filter that lets a glitch through adds a clock edge, so the byte written next is misaligned. Every readback and image comparison exposes that as soon as the transfer ends.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  localparam int REG_W     = 8;
  localparam int MAP_DEPTH = 24;
  localparam int PROFILES  = 4;
  localparam int SEL_W     = $clog2(PROFILES);
  localparam int INT_W     = 7;
  localparam int FRAC_W    = 18;
  localparam int ODIV_W    = 7;
  localparam int IDIV_W    = 3;

  // register bases the profile decoder depends on
  localparam int INT_LO_BASE   = 0;
  localparam int FRAC_HI_BASE  = 4;
  localparam int FRAC_MID_BASE = 8;
  localparam int ODIV_BASE     = 12;
  localparam int MISC_BASE     = 20;
  localparam int OUTCTL_REG    = 17;
  localparam int MODE_REG      = 18;

  localparam logic [MAP_DEPTH*REG_W-1:0] DEFAULT_IMAGE =
    192'h00000000_00400600_00000000_00000000_00000000_00000050;

  // strobes from the byte engine to the register bank
  typedef struct packed {
    logic             setPtr;
    logic             wrByte;
    logic             rdNext;
    logic [REG_W-1:0] data;
  } bankCmd_t;

  typedef enum logic [2:0] {
    BUS_IDLE, BUS_RX, BUS_ACK, BUS_TX, BUS_MACK, BUS_WAIT
  } busState_t;

  typedef enum logic [1:0] {RX_ADDR, RX_PTR, RX_DATA} rxKind_t;

  function automatic int bitIdx(input int regNum, input int bitNum);
    return regNum * REG_W + bitNum;
  endfunction
endpackage

// File: rtl/line_filter.sv
module line_filter #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  logic [1:0]       syncQ;
  logic [DEPTH-1:0] histQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '1;
      histQ    <= '1;
      cleanOut <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      histQ <= {histQ[DEPTH-2:0], syncQ[1]};
      if (&histQ)
        cleanOut <= 1'b1;
      else if (~|histQ)
        cleanOut <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
  import cfg_i2c_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'b1101110,
  parameter int         FILT_LEN    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [REG_W-1:0] rdData,
  output logic             sdaDriveLow,
  output bankCmd_t         cmd
);
  localparam int LINES = 2;
  localparam int CNT_W = $clog2(REG_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(REG_W - 1);

  logic [LINES-1:0] rawLines, cleanLines;
  assign rawLines = {sdaIn, sclIn};

  for (genvar i = 0; i < LINES; i++) begin : g_line
    line_filter #(.DEPTH(FILT_LEN)) u_filt (
      .clk     (clk),
      .rstN    (rstN),
      .rawIn   (rawLines[i]),
      .cleanOut(cleanLines[i])
    );
  end

  logic scl, sda, sclPrev, sdaPrev;
  assign scl = cleanLines[0];
  assign sda = cleanLines[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= scl;
      sdaPrev <= sda;
    end
  end

  logic sclRise, sclFall, startSeen, stopSeen;
  assign sclRise   = scl & ~sclPrev;
  assign sclFall   = ~scl & sclPrev;
  assign startSeen = scl & sclPrev & sdaPrev & ~sda;
  assign stopSeen  = scl & sclPrev & ~sdaPrev & sda;

  busState_t        state;
  rxKind_t          kind;
  logic [CNT_W-1:0] bitCnt;
  logic [REG_W-1:0] shiftQ, txQ;
  logic             byteDone, readMode, hostAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= BUS_IDLE;
      kind        <= RX_ADDR;
      bitCnt      <= '0;
      shiftQ      <= '0;
      txQ         <= '0;
      byteDone    <= 1'b0;
      readMode    <= 1'b0;
      hostAck     <= 1'b0;
      sdaDriveLow <= 1'b0;
      cmd         <= '0;
    end else begin
      cmd <= '0;
      if (startSeen) begin
        state       <= BUS_RX;
        kind        <= RX_ADDR;
        bitCnt      <= '0;
        byteDone    <= 1'b0;
        sdaDriveLow <= 1'b0;
      end else if (stopSeen) begin
        state       <= BUS_IDLE;
        sdaDriveLow <= 1'b0;
      end else begin
        case (state)
          BUS_RX: begin
            if (sclRise) begin
              shiftQ <= {shiftQ[REG_W-2:0], sda};
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == LAST_BIT) byteDone <= 1'b1;
            end else if (sclFall && byteDone) begin
              byteDone <= 1'b0;
              case (kind)
                RX_ADDR: begin
                  if (shiftQ[REG_W-1:1] == TARGET_ADDR) begin
                    readMode    <= shiftQ[0];
                    sdaDriveLow <= 1'b1;
                    state       <= BUS_ACK;
                  end else begin
                    state <= BUS_WAIT;
                  end
                end
                RX_PTR: begin
                  cmd.setPtr  <= 1'b1;
                  cmd.data    <= shiftQ;
                  sdaDriveLow <= 1'b1;
                  state       <= BUS_ACK;
                end
                default: begin
                  cmd.wrByte  <= 1'b1;
                  cmd.data    <= shiftQ;
                  sdaDriveLow <= 1'b1;
                  state       <= BUS_ACK;
                end
              endcase
            end
          end
          BUS_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (kind == RX_ADDR && readMode) begin
                txQ         <= rdData;
                sdaDriveLow <= ~rdData[REG_W-1];
                cmd.rdNext  <= 1'b1;
                state       <= BUS_TX;
              end else begin
                sdaDriveLow <= 1'b0;
                state       <= BUS_RX;
                kind        <= (kind == RX_ADDR) ? RX_PTR : RX_DATA;
              end
            end
          end
          BUS_TX: begin
            if (sclFall) begin
              if (bitCnt == LAST_BIT) begin
                sdaDriveLow <= 1'b0;
                state       <= BUS_MACK;
              end else begin
                txQ         <= {txQ[REG_W-2:0], 1'b0};
                sdaDriveLow <= ~txQ[REG_W-2];
                bitCnt      <= bitCnt + 1'b1;
              end
            end
          end
          BUS_MACK: begin
            if (sclRise) begin
              hostAck <= ~sda;
            end else if (sclFall) begin
              if (hostAck) begin
                txQ         <= rdData;
                sdaDriveLow <= ~rdData[REG_W-1];
                cmd.rdNext  <= 1'b1;
                bitCnt      <= '0;
                state       <= BUS_TX;
              end else begin
                state <= BUS_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_i2c_pkg::*;
#(
  parameter int                          NUM_REGS    = MAP_DEPTH,
  parameter logic [NUM_REGS*REG_W-1:0]   RESET_IMAGE = DEFAULT_IMAGE
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  bankCmd_t                  cmd,
  output logic [REG_W-1:0]          rdData,
  output logic [NUM_REGS*REG_W-1:0] regImage
);
  localparam int PTR_W = REG_W;
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_REGS - 1);

  logic [REG_W-1:0] regsQ [NUM_REGS];
  logic [PTR_W-1:0] ptrQ;
  logic             inRange;

  assign inRange = (ptrQ <= LAST_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
      for (int k = 0; k < NUM_REGS; k++)
        regsQ[k] <= RESET_IMAGE[k*REG_W +: REG_W];
    end else if (cmd.setPtr) begin
      ptrQ <= cmd.data;
    end else if (cmd.wrByte || cmd.rdNext) begin
      if (cmd.wrByte && inRange)
        regsQ[ptrQ[IDX_W-1:0]] <= cmd.data;
      if (ptrQ != '1)
        ptrQ <= ptrQ + 1'b1;
    end
  end

  assign rdData = inRange ? regsQ[ptrQ[IDX_W-1:0]] : '0;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_flat
    assign regImage[k*REG_W +: REG_W] = regsQ[k];
  end
endmodule

// File: rtl/cfg_profile_decode.sv
module cfg_profile_decode
  import cfg_i2c_pkg::*;
(
  input  logic [MAP_DEPTH*REG_W-1:0] image,
  output logic [SEL_W-1:0]           activeProfile,
  output logic [INT_W-1:0]           intDiv,
  output logic [FRAC_W-1:0]          fracDiv,
  output logic [ODIV_W-1:0]          outDiv,
  output logic [IDIV_W-1:0]          inDiv,
  output logic                       pllEnable,
  output logic                       refOutOff,
  output logic                       mainOutOff,
  output logic                       swingHigh
);
  logic [INT_W-1:0]  intAll  [PROFILES];
  logic [FRAC_W-1:0] fracAll [PROFILES];
  logic [ODIV_W-1:0] odivAll [PROFILES];
  logic [IDIV_W-1:0] idivAll [PROFILES];
  logic              unusedImageBits;

  for (genvar n = 0; n < PROFILES; n++) begin : g_prof
    assign intAll[n] = {image[bitIdx(MISC_BASE + n, 4)],
                        image[bitIdx(MISC_BASE + n, 5)],
                        image[bitIdx(INT_LO_BASE + n, 5) -: 5]};
    assign fracAll[n] = {image[bitIdx(INT_LO_BASE + n, 0)],
                         image[bitIdx(FRAC_HI_BASE + n, 7) -: 8],
                         image[bitIdx(FRAC_MID_BASE + n, 7) -: 8],
                         image[bitIdx(ODIV_BASE + n, 7)]};
    assign odivAll[n] = image[bitIdx(ODIV_BASE + n, 6) -: ODIV_W];
    assign idivAll[n] = {image[bitIdx(MISC_BASE + n, 3)],
                         image[bitIdx(MISC_BASE + n, 7) -: 2]};
  end

  assign activeProfile = image[bitIdx(MODE_REG, 5) -: SEL_W];
  assign intDiv        = intAll[activeProfile];
  assign fracDiv       = fracAll[activeProfile];
  assign outDiv        = odivAll[activeProfile];
  assign inDiv         = idivAll[activeProfile];
  assign pllEnable     = image[bitIdx(MODE_REG, 6)];
  assign refOutOff     = image[bitIdx(OUTCTL_REG, 3)];
  assign mainOutOff    = image[bitIdx(OUTCTL_REG, 2)];
  assign swingHigh     = image[bitIdx(OUTCTL_REG, 1)];

  // bits with no decoded meaning are still carried on the flat image
  assign unusedImageBits = ^image;
endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
  import cfg_i2c_pkg::*;
#(
  parameter logic [6:0]                 TARGET_ADDR = 7'b1101110,
  parameter int                         FILT_LEN    = 3,
  parameter logic [MAP_DEPTH*REG_W-1:0] RESET_IMAGE = DEFAULT_IMAGE
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclIn,
  input  logic                       sdaIn,
  output logic                       sdaDriveLow,
  output logic [MAP_DEPTH*REG_W-1:0] regImage,
  output logic [SEL_W-1:0]           activeProfile,
  output logic [INT_W-1:0]           intDiv,
  output logic [FRAC_W-1:0]          fracDiv,
  output logic [ODIV_W-1:0]          outDiv,
  output logic [IDIV_W-1:0]          inDiv,
  output logic                       pllEnable,
  output logic                       refOutOff,
  output logic                       mainOutOff,
  output logic                       swingHigh
);
  bankCmd_t         bankCmd;
  logic [REG_W-1:0] rdData;

  i2c_target_ctrl #(
    .TARGET_ADDR(TARGET_ADDR),
    .FILT_LEN   (FILT_LEN)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .rdData     (rdData),
    .sdaDriveLow(sdaDriveLow),
    .cmd        (bankCmd)
  );

  cfg_reg_bank #(
    .NUM_REGS   (MAP_DEPTH),
    .RESET_IMAGE(RESET_IMAGE)
  ) u_bank (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (bankCmd),
    .rdData  (rdData),
    .regImage(regImage)
  );

  cfg_profile_decode u_decode (
    .image        (regImage),
    .activeProfile(activeProfile),
    .intDiv       (intDiv),
    .fracDiv      (fracDiv),
    .outDiv       (outDiv),
    .inDiv        (inDiv),
    .pllEnable    (pllEnable),
    .refOutOff    (refOutOff),
    .mainOutOff   (mainOutOff),
    .swingHigh    (swingHigh)
  );
endmodule

// File: rtl/cfg_i2c_target_chk.sv
module cfg_i2c_target_chk
  import cfg_i2c_pkg::*;
(
  input logic                       clk,
  input logic                       rstN,
  input logic                       sclIn,
  input logic                       sdaDriveLow,
  input logic [MAP_DEPTH*REG_W-1:0] regImage,
  input bankCmd_t                   cmd
);
  // R1: the data line is released on the first cycle out of reset
  a_r1_released_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !sdaDriveLow);

  // R2: the target only starts pulling SDA low while SCL is low
  a_r2_drive_starts_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclIn);

  // R3: the byte engine issues at most one bank command per cycle
  a_r3_single_command: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.setPtr, cmd.wrByte, cmd.rdNext}));

  // R3: a write strobe changes no more than one register
  a_r3_write_touches_one_byte: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrByte |=> ($countones(regImage ^ $past(regImage)) <= REG_W));

  // R5: without a write strobe the map holds its contents
  a_r5_image_holds_without_write: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.wrByte |=> $stable(regImage));
endmodule

bind cfg_i2c_target cfg_i2c_target_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sclIn      (sclIn),
  .sdaDriveLow(sdaDriveLow),
  .regImage   (regImage),
  .cmd        (bankCmd)
);

// File: tb/test_cfg_i2c_target.sv
module test_cfg_i2c_target;
  import cfg_i2c_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int QP         = 10;
  localparam int WATCHDOG   = 190000;
  localparam logic [6:0] DEV_ADDR = 7'b1101110;
  localparam int NVEC = 8;
  // {pointer, byte written, byte expected on readback}
  localparam logic [23:0] VECS [NVEC] = '{
    24'h00A5A5, 24'h053C3C, 24'h0C8181, 24'h14C9C9,
    24'h177E7E, 24'h18FF00, 24'h281200, 24'h110E0E
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1, sclGlitch = 1'b0;
  logic sdaDriveLow;
  wire  sclLine = mScl & ~sclGlitch;
  wire  sdaLine = mSda & ~sdaDriveLow;

  logic [191:0] regImage;
  logic [1:0]   activeProfile;
  logic [6:0]   intDiv, outDiv;
  logic [17:0]  fracDiv;
  logic [2:0]   inDiv;
  logic         pllEnable, refOutOff, mainOutOff, swingHigh;

  cfg_i2c_target i_cfg_i2c_target (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .regImage(regImage),
    .activeProfile(activeProfile), .intDiv(intDiv), .fracDiv(fracDiv),
    .outDiv(outDiv), .inDiv(inDiv), .pllEnable(pllEnable),
    .refOutOff(refOutOff), .mainOutOff(mainOutOff), .swingHigh(swingHigh)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nFails = 0;
  logic [7:0] model [24];
  logic [7:0] wbuf  [24];
  logic [7:0] rbuf  [24];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [191:0] modelImage();
    logic [191:0] img;
    for (int k = 0; k < 24; k++) img[k*8 +: 8] = model[k];
    return img;
  endfunction

  task automatic checkImage(input string req);
    nChecks++;
    if (regImage !== modelImage()) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, regImage, modelImage());
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic busStart();
    if (!mScl) begin
      mSda = 1'b1; tick(QP);
      mScl = 1'b1; tick(QP);
    end
    mSda = 1'b0; tick(QP);
    mScl = 1'b0; tick(QP);
  endtask

  task automatic busStop();
    mSda = 1'b0; tick(QP);
    mScl = 1'b1; tick(QP);
    mSda = 1'b1; tick(2*QP);
  endtask

  task automatic putBit(input logic b, input logic glitch);
    mSda = b; tick(QP);
    mScl = 1'b1; tick(QP);
    if (glitch) begin
      sclGlitch = 1'b1; tick(1);
      sclGlitch = 1'b0; tick(QP-1);
    end else begin
      tick(QP);
    end
    mScl = 1'b0; tick(QP);
  endtask

  task automatic getBit(output logic b);
    mSda = 1'b1; tick(QP);
    mScl = 1'b1; tick(QP);
    b = sdaLine; tick(QP);
    mScl = 1'b0; tick(QP);
  endtask

  task automatic sendByte(input logic [7:0] v, input int glitchBit, output logic acked);
    logic bv;
    for (int i = 7; i >= 0; i--) putBit(v[i], i == glitchBit);
    getBit(bv);
    acked = !bv;
  endtask

  task automatic recvByte(input logic lastOne, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) getBit(v[i]);
    putBit(lastOne, 1'b0);
  endtask

  task automatic writeRegs(input logic [7:0] ptr, input int count, output int acks);
    logic a;
    acks = 0;
    busStart();
    sendByte({DEV_ADDR, 1'b0}, -1, a); acks += int'(a);
    sendByte(ptr, -1, a);              acks += int'(a);
    for (int i = 0; i < count; i++) begin
      sendByte(wbuf[i], -1, a);        acks += int'(a);
    end
    busStop();
  endtask

  task automatic readRegs(input logic [7:0] ptr, input int count, output int acks);
    logic a;
    acks = 0;
    busStart();
    sendByte({DEV_ADDR, 1'b0}, -1, a); acks += int'(a);
    sendByte(ptr, -1, a);              acks += int'(a);
    busStart();
    sendByte({DEV_ADDR, 1'b1}, -1, a); acks += int'(a);
    for (int i = 0; i < count; i++) recvByte(i == count - 1, rbuf[i]);
  endtask

  function automatic logic [6:0] expInt(input int n);
    return {model[20+n][4], model[20+n][5], model[n][5:1]};
  endfunction
  function automatic logic [17:0] expFrac(input int n);
    return {model[n][0], model[4+n], model[8+n], model[12+n][7]};
  endfunction
  function automatic logic [2:0] expIn(input int n);
    return {model[20+n][3], model[20+n][7:6]};
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    int acks;
    logic a;
    for (int k = 0; k < 24; k++) model[k] = 8'h00;
    model[0] = 8'h50; model[17] = 8'h06; model[18] = 8'h40;

    // R1 reset state
    tick(5);
    check("R1 drive in reset", sdaDriveLow, 0);
    rstN = 1'b1;
    tick(5);
    check("R1 drive after reset", sdaDriveLow, 0);
    checkImage("R1 R12 reset image");
    check("R7 default int divider", intDiv, 7'd8);
    check("R10 default pll enable", pllEnable, 1);
    check("R10 default output controls", {refOutOff, mainOutOff, swingHigh}, 3'b011);

    // R2 foreign address: no ack, data ignored
    busStart();
    sendByte({7'b1101111, 1'b0}, -1, a);
    check("R2 foreign address not acked", a, 0);
    sendByte(8'h00, -1, a);
    sendByte(8'hEE, -1, a);
    busStop();
    checkImage("R2 foreign transfer ignored");

    // R3 R6 table of single writes with readback
    for (int v = 0; v < NVEC; v++) begin
      wbuf[0] = VECS[v][15:8];
      writeRegs(VECS[v][23:16], 1, acks);
      check("R2 R3 R6 write acks", acks, 3);
      if (VECS[v][23:16] < 8'd24) model[VECS[v][23:16]] = VECS[v][15:8];
      checkImage("R3 R6 R12 image after write");
      readRegs(VECS[v][23:16], 1, acks);
      busStop();
      check("R4 read acks", acks, 3);
      check("R3 R6 readback", rbuf[0], VECS[v][7:0]);
    end
    check("R10 controls after write", {refOutOff, mainOutOff, swingHigh}, 3'b111);

    // R3 block write, R4 block read
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    writeRegs(8'd8, 4, acks);
    for (int i = 0; i < 4; i++) model[8+i] = wbuf[i];
    check("R3 block write acks", acks, 6);
    checkImage("R3 block write image");
    readRegs(8'd8, 4, acks);
    check("R4 no drive after nack", sdaDriveLow, 0);
    busStop();
    for (int i = 0; i < 4; i++) check("R4 block read byte", rbuf[i], wbuf[i]);

    // R5 transfer cut after one data byte, and after pointer only
    wbuf[0] = 8'h5A;
    writeRegs(8'd2, 1, acks);
    model[2] = 8'h5A;
    checkImage("R5 partial write keeps neighbours");
    writeRegs(8'd3, 0, acks);
    checkImage("R5 pointer only changes nothing");

    // R6 read running past the end of the map
    readRegs(8'd22, 3, acks);
    busStop();
    check("R6 read reg22", rbuf[0], model[22]);
    check("R6 read reg23", rbuf[1], model[23]);
    check("R6 read beyond map", rbuf[2], 8'h00);

    // R11 glitch on SCL during a data bit
    busStart();
    sendByte({DEV_ADDR, 1'b0}, -1, a);
    sendByte(8'd9, -1, a);
    sendByte(8'h96, 4, a);
    busStop();
    model[9] = 8'h96;
    check("R11 glitched byte acked", a, 1);
    checkImage("R11 glitch ignored");

    // R7 R8 R9 R10 profile decode
    for (int k = 0; k < 24; k++) wbuf[k] = 8'((k * 37 + 11) ^ (k << 4));
    wbuf[17] = 8'h08; wbuf[18] = 8'h00;
    writeRegs(8'd0, 24, acks);
    for (int k = 0; k < 24; k++) model[k] = wbuf[k];
    checkImage("R3 full map write");
    check("R10 controls", {refOutOff, mainOutOff, swingHigh}, 3'b100);
    for (int n = 0; n < 4; n++) begin
      wbuf[0] = {1'b0, n[0], n[1:0], 4'b0101};
      writeRegs(8'd18, 1, acks);
      model[18] = wbuf[0];
      check("R10 active profile", activeProfile, n);
      check("R10 pll enable", pllEnable, n[0]);
      check("R7 int divider", intDiv, expInt(n));
      check("R8 fraction", fracDiv, expFrac(n));
      check("R9 output divider", outDiv, model[12+n][6:0]);
      check("R9 input divider", inDiv, expIn(n));
    end
    checkImage("R12 final image");

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule